// File: doc/BRIEF.md
# Stop-State Wake-Up Warm-Up Controller

This controller governs a deep halt state in which the main oscillator and every clock derived from it are switched off. While the processor is running, a stop request moves the controller into the halted state. It drops the oscillator enable and closes the system clock gate. An interrupt request releases the halt. The controller then re-enables the oscillator and counts its rising edges over an interval chosen by software. Only when that interval is complete does it reopen the system clock and report that execution may resume.

The interval is picked by a two-bit select. The controller captures the select when the halt begins, so software may rewrite it while halted without disturbing the interval in progress. The oscillator enable is formed combinationally from the interrupt request, so a halted controller needs no running clock to notice a wake-up. The clock gate moves only while the oscillator output is low, and the gated system clock therefore never carries a shortened pulse.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, `run`, `osc_en` and `sys_clk_on` are all 1.
- R2: When `stop_req` is 1 at a rising `osc_clk` edge while `run` is 1, `run` is 0 after that edge. With `irq_req` at 0, `osc_en` is then 0 and `sys_clk` stays low.
- R3: While halted, `osc_en` follows `irq_req` at once. The first rising `osc_clk` edge that finds `irq_req` at 1 starts the warm-up.
- R4: `run` returns to 1 after exactly N rising `osc_clk` edges, counting the starting edge as the first. Select 01 gives N = 2^SHORT_LOG, select 10 gives N = 2^MID_LOG, and select 11 gives N = 2^LONG_LOG. Select 00 behaves as 11.
- R5: `sys_clk_on` follows `run` at the next falling `osc_clk` edge and never changes while `osc_clk` is high. `sys_clk` is `osc_clk` masked by `sys_clk_on`.
- R6: The select is captured at the edge that enters the halt. Values written to `warm_sel` later do not change N.
- R7: A `stop_req` during warm-up is ignored. N is unchanged, and `run` stays 1 once it returns.
- R8: `irq_req` has no effect while `run` is 1, and holding it high during warm-up does not change N.
- R9: If `stop_req` and `irq_req` are both 1 at the same edge while running, the controller halts for one cycle with `osc_en` kept at 1. The next rising edge starts the warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_clk | input | 1 | Raw oscillator clock |
| stop_req | input | 1 | Request to enter the halt state |
| irq_req | input | 1 | Enabled interrupt request, level held until acknowledged |
| warm_sel | input | 2 | Warm-up interval select |
| osc_en | output | 1 | Enable to the oscillator |
| sys_clk | output | 1 | Gated system clock |
| sys_clk_on | output | 1 | System clock gate state |
| run | output | 1 | Processor may execute |

## Verification
Halt entry and wake-up can fall on the same edge. This happens when `stop_req` and `irq_req` are high together while the controller is running. The bench drives this case for every select code. It then checks that `run` falls, that `osc_en` never drops, and that the warm-up length counted from the following edge is exactly the length the select implies. The same sweep rewrites the select while halted, holds the interrupt through the warm-up, and issues a stop request mid-interval, each judged by the counted edge total.

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
  parameter int unsigned SHORT_LOG = 8,
  parameter int unsigned MID_LOG   = 14,
  parameter int unsigned LONG_LOG  = 16
) (
  input  logic       rst_n,
  input  logic       osc_clk,
  input  logic       stop_req,
  input  logic       irq_req,
  input  logic [1:0] warm_sel,
  output logic       osc_en,
  output logic       sys_clk,
  output logic       sys_clk_on,
  output logic       run
);

  localparam int unsigned CW = LONG_LOG;

  typedef enum logic [1:0] {S_RUN, S_STOP, S_WARM} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [1:0]      sel_q;
  logic [CW-1:0]   lim;
  logic            gate_q;

  function automatic logic [CW-1:0] last_count(input logic [1:0] code);
    logic [CW-1:0] ones;
    ones = '1;
    case (code)
      2'b01:   return ones >> (CW - SHORT_LOG);
      2'b10:   return ones >> (CW - MID_LOG);
      default: return ones;
    endcase
  endfunction

  assign lim = last_count(sel_q);

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_RUN;
      cnt   <= '0;
      sel_q <= 2'b11;
    end else begin
      case (st)
        S_RUN:
          if (stop_req) begin
            st    <= S_STOP;
            cnt   <= '0;
            sel_q <= warm_sel;
          end
        S_STOP:
          if (irq_req) begin
            st  <= S_WARM;
            cnt <= CW'(1);
          end
        S_WARM:
          if (cnt == lim) st <= S_RUN;
          else            cnt <= cnt + 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(negedge osc_clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= (st == S_RUN);
  end

  assign run        = (st == S_RUN);
  assign osc_en     = (st != S_STOP) | irq_req;
  assign sys_clk_on = gate_q;
  assign sys_clk    = osc_clk & gate_q;

  a_r2_stop_entry: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (run && stop_req) |=> !run);

  a_r3_irq_wakes: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == S_STOP && irq_req) |=> (st == S_WARM));

  a_r4_full_count: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(st == S_RUN) |-> (cnt == lim));

  a_r5_gate_closed: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st != S_RUN) |-> !gate_q);

  a_r6_sel_held: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st != S_RUN) |=> $stable(sel_q));

  a_r7_no_restop: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == S_WARM) |=> (st != S_STOP));

  a_r8_count_bound: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == S_WARM) |-> (cnt <= lim));

endmodule

// File: tb/stop_wake_ctrl_test.sv
module stop_wake_ctrl_test;
  localparam int unsigned SL = 4, ML = 6, LL = 8;

  logic rst_n = 1'b0, osc_clk = 1'b0, stop_req = 1'b0, irq_req = 1'b0;
  logic [1:0] warm_sel = 2'b11;
  logic osc_en, sys_clk, sys_clk_on, run;
  int unsigned total = 0, fails = 0;
  bit done = 1'b0, live = 1'b0;

  stop_wake_ctrl #(.SHORT_LOG(SL), .MID_LOG(ML), .LONG_LOG(LL)) uut (
    .rst_n(rst_n), .osc_clk(osc_clk), .stop_req(stop_req), .irq_req(irq_req),
    .warm_sel(warm_sel), .osc_en(osc_en), .sys_clk(sys_clk),
    .sys_clk_on(sys_clk_on), .run(run));

  // 125 MHz oscillator model: output rests low while disabled
  initial forever begin
    #4;
    if (osc_en) osc_clk = ~osc_clk;
    else        osc_clk = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R5: gate must not move during the high phase
  always @(sys_clk_on) if (live) chk(!osc_clk, "R5 gate moved while clock high", int'(osc_clk), 0);

  function automatic int exp_len(input logic [1:0] code);
    case (code)
      2'b01:   return 1 << SL;
      2'b10:   return 1 << ML;
      default: return 1 << LL;
    endcase
  endfunction

  task automatic halt_and_wake(input logic [1:0] sel, input logic [1:0] later,
                               input bit joint, input bit hold_irq, input bit poke);
    int n;
    @(posedge osc_clk); #1;
    warm_sel = sel; stop_req = 1'b1; irq_req = joint;
    @(posedge osc_clk); #1;
    stop_req = 1'b0; warm_sel = later;
    chk(run == 1'b0, "R2 run after stop", int'(run), 0);
    if (!joint) begin
      chk(osc_en == 1'b0, "R2 osc_en in halt", int'(osc_en), 0);
      #40;
      chk(sys_clk == 1'b0, "R2 sys_clk in halt", int'(sys_clk), 0);
      chk(sys_clk_on == 1'b0, "R5 gate in halt", int'(sys_clk_on), 0);
      irq_req = 1'b1;
      #1;
      chk(osc_en == 1'b1, "R3 osc_en follows irq", int'(osc_en), 1);
    end else begin
      chk(osc_en == 1'b1, "R9 osc_en kept", int'(osc_en), 1);
    end
    n = 0;
    do begin
      @(posedge osc_clk); #1;
      n++;
      if (!hold_irq) irq_req = 1'b0;
      if (poke && n == 2) stop_req = 1'b1;
      if (poke && n == 3) stop_req = 1'b0;
    end while (!run && n < 5000);
    irq_req = 1'b0; stop_req = 1'b0;
    chk(n == exp_len(sel), joint ? "R9 R4 R6 warm-up length" :
        (poke ? "R7 R4 warm-up length" : (hold_irq ? "R8 R4 warm-up length" : "R4 R6 warm-up length")),
        n, exp_len(sel));
    chk(sys_clk_on == 1'b0, "R5 gate before fall", int'(sys_clk_on), 0);
    @(negedge osc_clk); #1;
    chk(sys_clk_on == 1'b1, "R5 gate after fall", int'(sys_clk_on), 1);
    repeat (3) @(posedge osc_clk);
    #1;
    chk(run == 1'b1, "R7 run stays", int'(run), 1);
  endtask

  initial begin
    #20;
    chk(run == 1'b1, "R1 run", int'(run), 1);
    chk(osc_en == 1'b1, "R1 osc_en", int'(osc_en), 1);
    chk(sys_clk_on == 1'b1, "R1 gate", int'(sys_clk_on), 1);
    @(negedge osc_clk); rst_n = 1'b1;
    live = 1'b1;
    @(posedge osc_clk); #1;
    irq_req = 1'b1;
    repeat (5) begin
      @(posedge osc_clk); #1;
      chk(run == 1'b1 && osc_en == 1'b1, "R8 irq while running", int'(run), 1);
    end
    irq_req = 1'b0;
    for (int s = 0; s < 4; s++)
      for (int l = 0; l < 4; l++)
        for (int j = 0; j < 2; j++)
          halt_and_wake(2'(s), 2'(l), bit'(j), bit'(l[0]), bit'(l[1]));
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule